// File: doc/BRIEF.md
# Vector Element Extract Unit

This block pulls a single element out of a vector register and hands it back as a scalar for write-back into an integer register. It receives the whole vector register as one flat bus, an element-width code, a scalar index read from a general-purpose register, a flag that is set when that index comes from the hard-wired zero register, the raw 32-bit instruction word and a valid strobe. It decodes the instruction word itself. It produces a registered scalar result, the destination register number and a result-valid strobe.

The element is selected with an index that is masked to the number of elements per register, so the selection never reaches past the register. Separately, the full index is compared as an unsigned value against the element count, and an index that is out of range forces the result to zero. When the index comes from the zero register, element 0 is returned with no check. Elements narrower than the scalar width are zero-extended.

Top module: `vec_elem_extract`

## Requirements
- R1: `insn_match` is high exactly when instr[31:26]=001100, instr[25]=1, instr[14:12]=010 and instr[6:0]=1010111. Bits 24:15 and 11:7 have no effect on it.
- R2: `out_valid` is high in the cycle after a cycle where `in_valid` and `insn_match` are both high, and low otherwise. An input that does not match produces no result.
- R3: `out_rd` carries instr[11:7] of the accepted instruction in the same cycle as `out_valid`.
- R4: Width code 0, 1, 2 and 3 selects 8, 16, 32 and 64-bit elements. Element i occupies bits [i*W +: W] of `vreg`.
- R5: The selected element is zero-extended to XLEN bits.
- R6: When `idx_is_x0` is high, element 0 is returned, whatever the value on `idx`.
- R7: When `idx_is_x0` is low and the full XLEN-bit `idx`, taken as unsigned, is not less than VLEN >> (3+code), the result is zero. This holds even when the low index bits alone would address a valid element.
- R8: For an in-range index, every element up to and including the last one (count−1) is returned correctly.
- R9: When XLEN is 32, width code 3 is treated as code 2 (32-bit elements).
- R10: While `rst` is high, `out_valid` and `out_data` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present |
| instr | input | 32 | Raw instruction word |
| vreg | input | VLEN | Source vector register contents |
| sew | input | 2 | Element width code |
| idx | input | XLEN | Scalar element index |
| idx_is_x0 | input | 1 | Index source register is the zero register |
| insn_match | output | 1 | Combinational decode hit on the extract encoding |
| out_valid | output | 1 | Registered result strobe |
| out_rd | output | 5 | Destination register number of the result |
| out_data | output | XLEN | Zero-extended extracted element |

## Verification
The vector register is filled with a byte pattern in which every byte is distinct. A wrong element, a wrong width or a missing zero-extension therefore shows up as a different value. Each width code is tried with index 0, with a middle index and with the last element, which separates a correct shift from an off-by-one. The out-of-range cases use indices equal to the count, large values whose low bits alias to valid elements, and the all-ones value. These catch a compare that uses only the masked bits. The zero-register flag is paired with a large index to show that the flag alone forces element 0. Instruction words with single decode bits flipped show that the strobe stays low, and words with changed free fields show that it still fires.

// File: rtl/vext_pkg.sv
package vext_pkg;
  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_code_e;

  localparam logic [5:0] OP_F6     = 6'b001100;
  localparam logic [2:0] OP_F3     = 3'b010;
  localparam logic [6:0] OP_MAJOR  = 7'b1010111;

  // Fold a width code onto what a given scalar width can hold.
  function automatic logic [1:0] clamp_code(input logic [1:0] code, input int xlen);
    if (xlen < 64 && code == EW64) return EW32;
    return code;
  endfunction
endpackage

// File: rtl/vext_decode.sv
module vext_decode (
  input  logic [31:0] instr,
  output logic        hit,
  output logic [4:0]  rd
);
  import vext_pkg::*;
  logic f6_ok, f3_ok, op_ok;
  always_comb begin
    f6_ok = (instr[31:26] == OP_F6) && instr[25];
    f3_ok = (instr[14:12] == OP_F3);
    op_ok = (instr[6:0] == OP_MAJOR);
    hit   = f6_ok && f3_ok && op_ok;
    rd    = instr[11:7];
  end
endmodule

// File: rtl/vext_range.sv
module vext_range #(
  parameter int VLEN = 128,
  parameter int XLEN = 64
) (
  input  logic [1:0]      code,
  input  logic [XLEN-1:0] idx,
  input  logic            from_x0,
  output logic [XLEN-1:0] count,
  output logic            in_range
);
  always_comb begin
    count    = XLEN'(VLEN) >> (32'd3 + 32'(code));
    in_range = from_x0 || (idx < count);
  end
endmodule

// File: rtl/vext_select.sv
module vext_select #(
  parameter int VLEN = 128,
  parameter int XLEN = 64
) (
  input  logic [VLEN-1:0] vreg,
  input  logic [1:0]      code,
  input  logic [XLEN-1:0] idx,
  input  logic            from_x0,
  output logic [XLEN-1:0] elem
);
  localparam int NBYTES = VLEN / 8;
  localparam int IDXW   = $clog2(NBYTES);
  localparam int POSW   = $clog2(VLEN);
  localparam int NWID   = (XLEN >= 64) ? 4 : 3;

  logic [IDXW-1:0] raw_idx;
  logic [XLEN-1:0] per_width [NWID];

  assign raw_idx = from_x0 ? '0 : idx[IDXW-1:0];

  for (genvar k = 0; k < NWID; k++) begin : g_width
    localparam int W   = 8 << k;
    localparam int CNT = VLEN / W;
    logic [IDXW-1:0] masked;
    logic [POSW-1:0] bitpos;
    assign masked = raw_idx & IDXW'(CNT - 1);
    assign bitpos = POSW'(masked) << (3 + k);
    assign per_width[k] = XLEN'(vreg[bitpos +: W]);
  end

  always_comb begin
    elem = per_width[0];
    for (int k = 1; k < NWID; k++)
      if (int'(code) == k) elem = per_width[k];
  end
endmodule

// File: rtl/vec_elem_extract.sv
module vec_elem_extract #(
  parameter int VLEN = 128,
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [VLEN-1:0] vreg,
  input  logic [1:0]      sew,
  input  logic [XLEN-1:0] idx,
  input  logic            idx_is_x0,
  output logic            insn_match,
  output logic            out_valid,
  output logic [4:0]      out_rd,
  output logic [XLEN-1:0] out_data
);
  import vext_pkg::*;

  logic [4:0]      dec_rd;
  logic [1:0]      code;
  logic [XLEN-1:0] elem;
  logic [XLEN-1:0] count;
  logic            in_range;
  logic            accept;

  assign code   = clamp_code(sew, XLEN);
  assign accept = in_valid && insn_match;

  vext_decode u_dec (.instr(instr), .hit(insn_match), .rd(dec_rd));

  vext_range #(.VLEN(VLEN), .XLEN(XLEN)) u_rng (
    .code(code), .idx(idx), .from_x0(idx_is_x0),
    .count(count), .in_range(in_range)
  );

  vext_select #(.VLEN(VLEN), .XLEN(XLEN)) u_sel (
    .vreg(vreg), .code(code), .idx(idx), .from_x0(idx_is_x0), .elem(elem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_rd    <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_data <= in_range ? elem : '0;
        out_rd   <= dec_rd;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !out_valid);
  a_r3_rd_pass: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_rd == $past(instr[11:7]));
  a_r5_byte_zext: assert property (@(posedge clk) disable iff (rst)
    (accept && code == 2'd0) |=> out_data[XLEN-1:8] == '0);
  a_r6_x0_elem0: assert property (@(posedge clk) disable iff (rst)
    (accept && idx_is_x0 && code == 2'd0) |=> out_data[7:0] == $past(vreg[7:0]));
  a_r7_oob_zero: assert property (@(posedge clk) disable iff (rst)
    (accept && !idx_is_x0 && idx >= count) |=> out_data == '0);
  a_r10_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_data == '0));
endmodule

// File: tb/test_vec_elem_extract.sv
module test_vec_elem_extract;
  localparam int VLEN  = 128;
  localparam int XLEN  = 64;
  localparam int NVLEN = 64;
  localparam int NXLEN = 32;

  logic clk = 0;
  logic rst = 1;
  always #5 clk = ~clk;

  logic            in_valid;
  logic [31:0]     instr;
  logic [VLEN-1:0] vreg;
  logic [1:0]      sew;
  logic [XLEN-1:0] idx;
  logic            idx_is_x0;
  logic            insn_match, out_valid;
  logic [4:0]      out_rd;
  logic [XLEN-1:0] out_data;

  logic             n_match, n_valid;
  logic [4:0]       n_rd;
  logic [NXLEN-1:0] n_data;

  int checks = 0;
  int fails  = 0;

  vec_elem_extract #(.VLEN(VLEN), .XLEN(XLEN)) i_vec_elem_extract (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .vreg(vreg),
    .sew(sew), .idx(idx), .idx_is_x0(idx_is_x0), .insn_match(insn_match),
    .out_valid(out_valid), .out_rd(out_rd), .out_data(out_data)
  );

  vec_elem_extract #(.VLEN(NVLEN), .XLEN(NXLEN)) i_narrow (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .vreg(vreg[NVLEN-1:0]),
    .sew(sew), .idx(idx[NXLEN-1:0]), .idx_is_x0(idx_is_x0), .insn_match(n_match),
    .out_valid(n_valid), .out_rd(n_rd), .out_data(n_data)
  );

  function automatic logic [31:0] enc(input logic [4:0] rs2, rs1, rd);
    return {6'b001100, 1'b1, rs2, rs1, 3'b010, rd, 7'b1010111};
  endfunction

  function automatic logic [XLEN-1:0] model(input logic [1:0] c, input logic [XLEN-1:0] ix,
                                             input logic x0);
    int w = 8 << c;
    longint unsigned cnt = VLEN >> (3 + c);
    logic [XLEN-1:0] r = '0;
    if (x0) ix = '0;
    if (ix >= cnt) return '0;
    for (int b = 0; b < w; b++) r[b] = vreg[int'(ix) * w + b];
    return r;
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic [1:0] c,
                       input logic [XLEN-1:0] ix, input logic x0);
    @(negedge clk);
    in_valid = 1; instr = ins; sew = c; idx = ix; idx_is_x0 = x0;
    @(posedge clk);
    #1;
    in_valid = 0;
  endtask

  task automatic extract_case(input string req, input logic [1:0] c,
                              input logic [XLEN-1:0] ix, input logic x0);
    logic [XLEN-1:0] exp = model(c, ix, x0);
    issue(enc(5'd3, x0 ? 5'd0 : 5'd9, 5'd17), c, ix, x0);
    check({req, " valid"}, XLEN'(out_valid), 1);
    check(req, out_data, exp);
  endtask

  task automatic t_reset;
    check("R10 valid", XLEN'(out_valid), 0);
    check("R10 data", out_data, 0);
  endtask

  task automatic t_decode;
    logic [31:0] good = enc(5'd5, 5'd6, 5'd7);
    #1;
    instr = good; #1;
    check("R1 hit", XLEN'(insn_match), 1);
    instr = {good[31:25], 10'h3ff, good[14:12], 5'h1f, good[6:0]}; #1;
    check("R1 free fields", XLEN'(insn_match), 1);
    instr = good ^ 32'h0200_0000; #1;
    check("R1 bit25", XLEN'(insn_match), 0);
    instr = good ^ 32'h0000_1000; #1;
    check("R1 funct3", XLEN'(insn_match), 0);
    instr = good ^ 32'h8000_0000; #1;
    check("R1 funct6", XLEN'(insn_match), 0);
    instr = good ^ 32'h0000_0001; #1;
    check("R1 opcode", XLEN'(insn_match), 0);
  endtask

  task automatic t_nomatch;
    issue(enc(5'd1, 5'd2, 5'd3) ^ 32'h0000_4000, 2'd0, 0, 0);
    check("R2 no result", XLEN'(out_valid), 0);
    @(posedge clk); #1;
    check("R2 drop", XLEN'(out_valid), 0);
  endtask

  task automatic t_rd;
    issue(enc(5'd2, 5'd4, 5'd29), 2'd1, 3, 0);
    check("R3 rd", XLEN'(out_rd), 29);
    @(posedge clk); #1;
    check("R2 one cycle", XLEN'(out_valid), 0);
  endtask

  task automatic t_widths;
    for (int c = 0; c < 4; c++) begin
      extract_case("R4 first", 2'(c), 0, 0);
      extract_case("R4 mid", 2'(c), 1, 0);
      extract_case("R8 last", 2'(c), XLEN'((VLEN >> (3 + c)) - 1), 0);
    end
    extract_case("R5 zext byte", 2'd0, 15, 0);
    check("R5 upper", out_data >> 8, 0);
  endtask

  task automatic t_x0;
    extract_case("R6 x0 big idx", 2'd0, 64'hffff_ffff_ffff_ff05, 1);
    check("R6 elem0", out_data, XLEN'(vreg[7:0]));
    extract_case("R6 x0 w64", 2'd3, 64'd1, 1);
  endtask

  task automatic t_oob;
    extract_case("R7 equal count", 2'd0, 16, 0);
    extract_case("R7 alias", 2'd1, 64'h1_0000_0002, 0);
    check("R7 alias zero", out_data, 0);
    extract_case("R7 all ones", 2'd3, '1, 0);
    extract_case("R7 just over", 2'd2, 4, 0);
  endtask

  task automatic t_narrow;
    issue(enc(5'd1, 5'd1, 5'd1), 2'd3, 1, 0);
    check("R9 code3 as 32", XLEN'(n_data), XLEN'(vreg[63:32]));
    issue(enc(5'd1, 5'd1, 5'd1), 2'd3, 2, 0);
    check("R9 range at 32", XLEN'(n_data), 0);
  endtask

  initial begin
    in_valid = 0; instr = 0; sew = 0; idx = 0; idx_is_x0 = 0;
    for (int b = 0; b < VLEN / 8; b++) vreg[b*8 +: 8] = 8'(b * 13 + 7);
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 0;
    t_decode();
    t_nomatch();
    t_rd();
    t_widths();
    t_x0();
    t_oob();
    t_narrow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #500000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule